// File: doc/BRIEF.md
# Receiver Sleep Command Controller

This block sequences a radio receiver between its sleep/polling state, a bit-check state and a full receiving state. The host can send it back to sleep in two ways. The first is through the shared, open-drain DATA line: the host holds the line low long enough, and the block then answers with a single sync pulse of its own on that line. This route works only when a configuration bit allows it. The second is through a dedicated ENABLE line, where a low level forces sleep at once.

After either command, a programmable sleep timer runs. When it expires, the receiver enters bit check. A sleep time of zero gives an immediate response. The minimum low time that the DATA route needs depends on the selected bit-rate range. It is taken from a small table that is supplied as a flat bus with one entry per range. All times are counted in clock cycles.

The `mode` output reports the state of the receiver. `data_pull_low` asks the pad to pull DATA low. The external line is the wired-AND of the host and this drive.

Top module: `rx_sleep_ctrl`

## Requirements
- R1: During and right after reset, `mode` is 2'b00 (sleep) and `data_pull_low` is 0. The mode codes are: 00 sleep, 01 bit check, 10 receiving, 11 OFF command in progress.
- R2: In sleep with `enable_in` high, `mode` becomes 01 on the max(`sleep_len`,1)-th clock edge that samples `enable_in` high.
- R3: In bit check, a `bitchk_pass` sampled high (with DATA high) moves `mode` to 10 on that edge. In receiving, the mode stays 10 until an OFF command arrives.
- R4: In bit check or receiving, with `data_off_allow` high, `mode` becomes 11 on the edge that samples DATA low for the max(t1,1)-th consecutive time. The value t1 is entry `rate_sel` of `t1_table`, where entry i occupies bits [i*TW +: TW].
- R5: With `data_off_allow` low, DATA low has no effect: the mode never becomes 11.
- R6: An OFF command holds `mode` at 11 for max(`gap_len`,1) + max(`tail_len`,1) cycles. During the first max(`gap_len`,1) cycles, the line is not driven. After that, exactly one low pulse of min(`sync_len`, max(`tail_len`,1)) cycles is driven at the start of the tail.
- R7: After an OFF command, `mode` is 00 for `sleep_len` cycles and then 01. When `sleep_len` is 0, the mode goes straight from 11 to 01.
- R8: `enable_in` sampled low forces `mode` to 00 on that edge from any mode. It aborts any OFF command and releases the drive. The mode stays 00 while `enable_in` is low, and the sleep count starts from the first high sample.
- R9: During the sleep countdown, an accepted DATA low of t1 cycles restarts the sleep count. Bit check then follows `sleep_len` edges after the triggering edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_in | input | 1 | Sensed level of the shared DATA line |
| data_pull_low | output | 1 | 1 = pull the DATA line low |
| enable_in | input | 1 | ENABLE line; low commands sleep |
| data_off_allow | input | 1 | Mode-register bit that permits the DATA-line OFF command |
| rate_sel | input | RSEL_W | Selected bit-rate range |
| t1_table | input | RANGES*TW | Minimum DATA-low time per range |
| gap_len | input | TW | Gap before the sync pulse (t2) |
| sync_len | input | TW | Sync pulse width (t3) |
| tail_len | input | TW | Tail window that holds the sync pulse (t10) |
| sleep_len | input | TW | Sleep time; 0 = immediate |
| bitchk_pass | input | 1 | Bit check succeeded |
| mode | output | 2 | 00 sleep, 01 bit check, 10 receiving, 11 OFF command |

## Verification
A wrong mode value shows on `mode` at the next edge, because the mode register drives the port directly. A timer that counts wrongly shows as a phase that is too long or too short: the OFF phase, the sync pulse or the sleep window. Such an error can be seen within one command. A low-run counter that is not cleared, or a gate that ignores `data_off_allow`, shows as an OFF entry that comes too early or that should not happen at all. Entry must occur on exactly the t1-th low sample.

// File: rtl/rx_sleep_ctrl.sv
module rx_sleep_ctrl #(
  parameter int TW     = 12,
  parameter int RANGES = 4,
  parameter int RSEL_W = $clog2(RANGES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 data_in,
  output logic                 data_pull_low,
  input  logic                 enable_in,
  input  logic                 data_off_allow,
  input  logic [RSEL_W-1:0]    rate_sel,
  input  logic [RANGES*TW-1:0] t1_table,
  input  logic [TW-1:0]        gap_len,
  input  logic [TW-1:0]        sync_len,
  input  logic [TW-1:0]        tail_len,
  input  logic [TW-1:0]        sleep_len,
  input  logic                 bitchk_pass,
  output logic [1:0]           mode
);
  localparam logic [1:0] M_SLEEP = 2'b00;
  localparam logic [1:0] M_CHECK = 2'b01;
  localparam logic [1:0] M_RECV  = 2'b10;
  localparam logic [1:0] M_OFF   = 2'b11;
  localparam logic [TW:0] ONE    = 1;

  logic [1:0]    mode_q;
  logic          tail_q;
  logic [TW-1:0] tmr_q, low_q;
  logic [TW-1:0] t1_sel;
  logic [TW:0]   tmr_nx, low_nx;
  logic          host_low, data_hit;

  assign t1_sel   = t1_table[int'(rate_sel)*TW +: TW];
  assign tmr_nx   = {1'b0, tmr_q} + ONE;
  assign low_nx   = {1'b0, low_q} + ONE;
  assign host_low = data_off_allow && !data_in;
  assign data_hit = host_low && (low_nx >= {1'b0, t1_sel});

  assign data_pull_low = (mode_q == M_OFF) && tail_q && (tmr_q < sync_len);
  assign mode = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_SLEEP;
      tail_q <= 1'b0;
      tmr_q  <= '0;
      low_q  <= '0;
    end else if (!enable_in) begin
      mode_q <= M_SLEEP;
      tail_q <= 1'b0;
      tmr_q  <= '0;
      low_q  <= '0;
    end else begin
      case (mode_q)
        M_SLEEP: begin
          if (data_hit) begin
            tmr_q <= '0;
            low_q <= '0;
          end else if (tmr_nx >= {1'b0, sleep_len}) begin
            mode_q <= M_CHECK;
            tmr_q  <= '0;
            low_q  <= '0;
          end else begin
            tmr_q <= tmr_nx[TW-1:0];
            low_q <= host_low ? low_nx[TW-1:0] : '0;
          end
        end
        M_CHECK, M_RECV: begin
          if (data_hit) begin
            mode_q <= M_OFF;
            tail_q <= 1'b0;
            tmr_q  <= '0;
            low_q  <= '0;
          end else begin
            low_q <= host_low ? low_nx[TW-1:0] : '0;
            if (mode_q == M_CHECK && bitchk_pass) mode_q <= M_RECV;
          end
        end
        default: begin
          if (!tail_q) begin
            if (tmr_nx >= {1'b0, gap_len}) begin
              tail_q <= 1'b1;
              tmr_q  <= '0;
            end else begin
              tmr_q <= tmr_nx[TW-1:0];
            end
          end else if (tmr_nx >= {1'b0, tail_len}) begin
            tail_q <= 1'b0;
            tmr_q  <= '0;
            mode_q <= (sleep_len == '0) ? M_CHECK : M_SLEEP;
          end else begin
            tmr_q <= tmr_nx[TW-1:0];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/rx_sleep_ctrl_chk.sv
module rx_sleep_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       data_in,
  input logic       data_pull_low,
  input logic       enable_in,
  input logic       data_off_allow,
  input logic       bitchk_pass,
  input logic [1:0] mode
);
  // R6
  pull_only_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_pull_low |-> mode == 2'b11);

  // R8
  en_low_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_in |=> (mode == 2'b00 && !data_pull_low));

  // R5
  gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_in && !data_off_allow && mode != 2'b11) |=> mode != 2'b11);

  // R3
  pass_to_recv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_in && mode == 2'b01 && bitchk_pass && data_in) |=> mode == 2'b10);

  // R3
  recv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_in && mode == 2'b10) |=> (mode == 2'b10 || mode == 2'b11));
endmodule

bind rx_sleep_ctrl rx_sleep_ctrl_chk i_chk (.*);

// File: tb/test_rx_sleep_ctrl.sv
`timescale 1ns/1ps
module test_rx_sleep_ctrl;
  localparam int TW = 12;
  localparam int RANGES = 4;
  localparam int RSEL_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_rel = 1'b1;
  logic data_in, data_pull_low;
  logic enable_in = 1'b1;
  logic data_off_allow = 1'b1;
  logic [RSEL_W-1:0] rate_sel = '0;
  logic [RANGES*TW-1:0] t1_table = '0;
  logic [TW-1:0] gap_len = '0, sync_len = '0, tail_len = '0, sleep_len = '0;
  logic bitchk_pass = 1'b0;
  logic [1:0] mode;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  assign data_in = host_rel & ~data_pull_low;

  rx_sleep_ctrl #(.TW(TW), .RANGES(RANGES), .RSEL_W(RSEL_W)) i_rx_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .data_pull_low(data_pull_low),
    .enable_in(enable_in), .data_off_allow(data_off_allow), .rate_sel(rate_sel),
    .t1_table(t1_table), .gap_len(gap_len), .sync_len(sync_len), .tail_len(tail_len),
    .sleep_len(sleep_len), .bitchk_pass(bitchk_pass), .mode(mode));

  function automatic int eff(int x);
    return (x == 0) ? 1 : x;
  endfunction

  function automatic int sync_w(int t3, int t10);
    return (t3 < eff(t10)) ? t3 : eff(t10);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_mode(logic [1:0] m, int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (mode != m && n < limit);
  endtask

  task automatic run_off(int t1v);
    int n, offc, pw, gapc, pulses, sc;
    bit prev;
    host_rel = 1'b0;
    wait_mode(2'b11, 500, n);
    chk(n == eff(t1v), "R4 edges to OFF", n, eff(t1v));
    host_rel = 1'b1;
    offc = 0; pw = 0; gapc = 0; pulses = 0; prev = 1'b0;
    do begin
      offc++;
      if (data_pull_low) begin
        pw++;
        if (!prev) pulses++;
      end else if (pw == 0) gapc++;
      prev = data_pull_low;
      @(negedge clk);
    end while (mode == 2'b11 && offc < 1000);
    chk(offc == eff(int'(gap_len)) + eff(int'(tail_len)), "R6 OFF length", offc,
        eff(int'(gap_len)) + eff(int'(tail_len)));
    chk(pw == sync_w(int'(sync_len), int'(tail_len)), "R6 sync width", pw,
        sync_w(int'(sync_len), int'(tail_len)));
    if (sync_w(int'(sync_len), int'(tail_len)) > 0) begin
      chk(gapc == eff(int'(gap_len)), "R6 gap before sync", gapc, eff(int'(gap_len)));
      chk(pulses == 1, "R6 single pulse", pulses, 1);
    end else begin
      chk(pulses == 0, "R6 no pulse", pulses, 0);
    end
    sc = 0;
    while (mode == 2'b00 && sc < 5000) begin
      sc++;
      @(negedge clk);
    end
    chk(sc == int'(sleep_len), "R7 sleep length", sc, int'(sleep_len));
    chk(mode == 2'b01, "R7 check after sleep", int'(mode), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    bit ok;
    void'($urandom(32'd20240611));
    sleep_len = 12'd5;
    for (int i = 0; i < RANGES; i++) t1_table[i*TW +: TW] = TW'(3 + 2*i);
    repeat (3) @(negedge clk);
    chk(mode == 2'b00, "R1 reset mode", int'(mode), 0);
    chk(data_pull_low == 1'b0, "R1 reset drive", int'(data_pull_low), 0);
    rst_n = 1'b1;
    chk(mode == 2'b00, "R1 mode after reset", int'(mode), 0);
    wait_mode(2'b01, 100, n);
    chk(n == 5, "R2 sleep to check", n, 5);

    bitchk_pass = 1'b1;
    @(negedge clk);
    bitchk_pass = 1'b0;
    chk(mode == 2'b10, "R3 pass to receive", int'(mode), 2);
    repeat (4) @(negedge clk);
    chk(mode == 2'b10, "R3 receive holds", int'(mode), 2);

    rate_sel = 2'd2; gap_len = 12'd3; sync_len = 12'd4; tail_len = 12'd6; sleep_len = 12'd7;
    run_off(7);

    data_off_allow = 1'b0;
    host_rel = 1'b0;
    ok = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (mode != 2'b01) ok = 1'b0;
    end
    host_rel = 1'b1;
    chk(ok, "R5 gated DATA ignored", int'(mode), 1);
    data_off_allow = 1'b1;
    @(negedge clk);

    bitchk_pass = 1'b1;
    @(negedge clk);
    bitchk_pass = 1'b0;
    sleep_len = 12'd4;
    enable_in = 1'b0;
    ok = 1'b1;
    repeat (10) begin
      @(negedge clk);
      if (mode != 2'b00) ok = 1'b0;
    end
    chk(ok, "R8 held in sleep while ENABLE low", int'(mode), 0);
    enable_in = 1'b1;
    wait_mode(2'b01, 100, n);
    chk(n == 4, "R8 sleep counted from release", n, 4);

    gap_len = 12'd3; sync_len = 12'd6; tail_len = 12'd10; rate_sel = 2'd0;
    host_rel = 1'b0;
    wait_mode(2'b11, 100, n);
    host_rel = 1'b1;
    n = 0;
    while (!data_pull_low && n < 50) begin
      n++;
      @(negedge clk);
    end
    enable_in = 1'b0;
    @(negedge clk);
    chk(mode == 2'b00 && !data_pull_low, "R8 ENABLE aborts OFF", int'(data_pull_low), 0);
    enable_in = 1'b1;
    sleep_len = 12'd0;
    wait_mode(2'b01, 100, n);
    chk(n == 1, "R7 zero sleep via ENABLE", n, 1);

    sleep_len = 12'd40;
    enable_in = 1'b0;
    @(negedge clk);
    enable_in = 1'b1;
    repeat (5) @(negedge clk);
    chk(mode == 2'b00, "R9 still sleeping", int'(mode), 0);
    host_rel = 1'b0;
    repeat (3) @(negedge clk);
    host_rel = 1'b1;
    wait_mode(2'b01, 200, n);
    chk(n == 40, "R9 sleep restarted", n, 40);

    for (int trial = 0; trial < 25; trial++) begin
      int tv;
      for (int i = 0; i < RANGES; i++) t1_table[i*TW +: TW] = TW'($urandom_range(0, 12));
      rate_sel  = RSEL_W'($urandom_range(0, RANGES-1));
      gap_len   = TW'($urandom_range(0, 6));
      sync_len  = TW'($urandom_range(0, 8));
      tail_len  = TW'($urandom_range(0, 10));
      sleep_len = TW'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 1) begin
        bitchk_pass = 1'b1;
        @(negedge clk);
        bitchk_pass = 1'b0;
      end
      tv = int'(t1_table[int'(rate_sel)*TW +: TW]);
      run_off(tv);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule